// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block speeds up 2D drawing on a framebuffer that holds one byte per pixel. Software reaches it through two word-wide command windows on a small request/response bus. Each operation is a pair of writes. The first write parks a colour. The second write carries the destination pixel in its bus address and starts the work. The engine then reaches the framebuffer through one synchronous single-port RAM, one access per cycle.

There are two windows. The stipple window turns a 32-bit mask into as many as 32 single-pixel writes of the parked colour. The blit window either fills a run of 1 to 32 pixels with the parked colour or copies such a run from a source pixel address. While an operation runs, `busy` stays high. A second start request is held off by pulling `bus_ready` low.

The bus side follows valid/ready rules. A request moves when `bus_valid` and `bus_ready` are both high at a rising clock edge. The driver must hold the request stable while `bus_ready` is low. `bus_ready` drops only for a start write that arrives while the engine is busy. Colour writes and reads are always accepted at once. `bus_rdata` is valid in the same cycle as an accepted read.

Top module: `pix_engine`

## Requirements
- R1: A write with bus address bit 2 clear only records the low byte of `bus_wdata` as the pending colour. It starts no operation and causes no RAM access.
- R2: A write with bus address bit 2 set starts an operation. The destination pixel address is taken from bus address bits PIX_AW+2 down to 3.
- R3: A stipple start (`bus_win`=0) looks at all 32 mask bits in turn. Data bit 31 covers the destination pixel, and each lower bit covers the next higher address. Pixels whose bit is 1 receive the colour that was pending when the operation started. Pixels whose bit is 0 keep their old value.
- R4: In a blit start (`bus_win`=1), data bits 28:24 hold the run length minus one, giving 1 to 32 pixels. When data bits 23:0 are not all ones, the run is copied from the source pixel address held in the low PIX_AW bits of the data.
- R5: In a blit start whose data bits 23:0 are all ones, the run is filled with the colour that was pending when the operation started.
- R6: Copies move one pixel at a time in ascending address order. When the source and destination runs overlap, the result is whatever that order produces.
- R7: A read from either window returns zero in the cycle it is accepted, is never stalled, and changes neither memory nor engine state.
- R8: `busy` rises in the cycle after a start is accepted. It stays high for exactly 32 cycles for a stipple, L cycles for a fill, and 2L cycles for a copy of L pixels.
- R9: A start write that arrives while `busy` is high sees `bus_ready` low until the engine is idle, and is then accepted and carried out.
- R10: A colour write accepted while `busy` is high does not change the operation in progress. It does apply to the next operation.
- R11: After reset `busy` is low, no RAM access is made, and the pending colour is zero.
- R12: Destination and source pixel addresses wrap modulo 2^PIX_AW as a run advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted when high with bus_valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window select: 0 = stipple, 1 = blit |
| bus_addr | input | PIX_AW+3 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PIX_AW | RAM pixel address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
The bench builds the engine with PIX_AW=10, a 1024-pixel framebuffer. At that size a byte-for-byte reference model of the whole RAM can be compared after every operation. Runs that start near the top address then wrap, so the modulo behaviour is exercised without a huge memory. The bench sweeps every blit length from 1 to 32, both as fills and as copies. Some copies overlap forward and some overlap backward. Stipple masks are run at several destinations. The bench also times each busy window and probes stalls and colour updates made while busy.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STIP = 3'd1,
    ST_FILL = 3'd2,
    ST_CRD  = 3'd3,
    ST_CWR  = 3'd4
  } pe_state_t;

  typedef enum logic [1:0] {
    OP_STIP = 2'd0,
    OP_FILL = 2'd1,
    OP_COPY = 2'd2
  } pe_op_t;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RUN_W    = 5;
  localparam int unsigned SRCF_W   = 24;
  localparam int unsigned PIX_W    = 8;
endpackage

// File: rtl/pe_cmd_decode.sv
module pe_cmd_decode
  import pe_pkg::*;
#(
  parameter int unsigned PIX_AW = 20,
  localparam int unsigned BUS_AW = PIX_AW + 3
) (
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              eng_busy,
  output logic              bus_ready,
  output logic              colour_wr,
  output logic              start,
  output pe_op_t            op,
  output logic [PIX_AW-1:0] dst,
  output logic [PIX_AW-1:0] src,
  output logic [RUN_W-1:0]  len_m1
);
  logic is_trig;
  logic fill_sel;

  assign is_trig   = bus_we && bus_addr[2];
  assign bus_ready = !(is_trig && eng_busy);
  assign colour_wr = bus_valid && bus_we && !bus_addr[2];
  assign start     = bus_valid && is_trig && !eng_busy;

  assign fill_sel = &bus_wdata[SRCF_W-1:0];
  assign dst      = bus_addr[PIX_AW+2:3];
  assign src      = bus_wdata[PIX_AW-1:0];
  assign len_m1   = bus_wdata[SRCF_W+RUN_W-1:SRCF_W];

  always_comb begin
    if (!bus_win)      op = OP_STIP;
    else if (fill_sel) op = OP_FILL;
    else               op = OP_COPY;
  end
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_pkg::*;
#(
  parameter int unsigned PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pe_op_t            op,
  input  logic [PIX_AW-1:0] dst,
  input  logic [PIX_AW-1:0] src,
  input  logic [RUN_W-1:0]  len_m1,
  input  logic [WORD_W-1:0] mask,
  input  logic [PIX_W-1:0]  colour,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  pe_state_t         state_q;
  logic [PIX_AW-1:0] dst_q, src_q;
  logic [RUN_W-1:0]  cnt_q;
  logic [WORD_W-1:0] mask_q;
  logic [PIX_W-1:0]  col_q;

  assign busy = (state_q != ST_IDLE);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dst_q;
    mem_wdata = col_q;
    unique case (state_q)
      ST_STIP: begin
        mem_en = mask_q[WORD_W-1];
        mem_we = mask_q[WORD_W-1];
      end
      ST_FILL: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      ST_CRD: begin
        mem_en   = 1'b1;
        mem_addr = src_q;
      end
      ST_CWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          dst_q  <= dst;
          src_q  <= src;
          mask_q <= mask;
          col_q  <= colour;
          unique case (op)
            OP_STIP: begin state_q <= ST_STIP; cnt_q <= '1;     end
            OP_FILL: begin state_q <= ST_FILL; cnt_q <= len_m1; end
            default: begin state_q <= ST_CRD;  cnt_q <= len_m1; end
          endcase
        end
        ST_STIP, ST_FILL: begin
          mask_q <= mask_q << 1;
          dst_q  <= dst_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == '0) state_q <= ST_IDLE;
        end
        ST_CRD: state_q <= ST_CWR;
        ST_CWR: begin
          dst_q   <= dst_q + 1'b1;
          src_q   <= src_q + 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == '0) ? ST_IDLE : ST_CRD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_engine.sv
module pix_engine
  import pe_pkg::*;
#(
  parameter int unsigned PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [PIX_AW+2:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic              colour_wr, start;
  pe_op_t            op;
  logic [PIX_AW-1:0] dst, src;
  logic [RUN_W-1:0]  len_m1;
  logic [PIX_W-1:0]  colour_q;

  assign bus_rdata = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)         colour_q <= '0;
    else if (colour_wr) colour_q <= bus_wdata[PIX_W-1:0];
  end

  pe_cmd_decode #(.PIX_AW(PIX_AW)) u_dec (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .eng_busy  (busy),
    .bus_ready (bus_ready),
    .colour_wr (colour_wr),
    .start     (start),
    .op        (op),
    .dst       (dst),
    .src       (src),
    .len_m1    (len_m1)
  );

  pe_sequencer #(.PIX_AW(PIX_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .dst       (dst),
    .src       (src),
    .len_m1    (len_m1),
    .mask      (bus_wdata),
    .colour    (colour_q),
    .busy      (busy),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int unsigned PIX_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [PIX_AW+2:0] bus_addr,
  input logic              busy,
  input logic              mem_en,
  input logic              mem_we
);
  // R8
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_we && bus_addr[2]) |=> busy);

  // R9
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (busy && bus_we && bus_addr[2]));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));

  // R7
  read_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |-> bus_ready);
endmodule

bind pix_engine pe_checker #(.PIX_AW(PIX_AW)) u_pe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .busy      (busy),
  .mem_en    (mem_en),
  .mem_we    (mem_we)
);

// File: tb/pix_engine_bench.sv
module pix_engine_bench;
  localparam int AW = 10;
  localparam int NPIX = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_we = 0, bus_win = 0;
  logic [AW+2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, busy, mem_en, mem_we;
  logic [31:0] bus_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] ram [NPIX];
  logic [7:0] ref_m [NPIX];
  logic [7:0] ref_col;
  int total = 0, bad = 0, busy_cnt;
  bit done = 0;

  always #4 clk = ~clk;

  pix_engine #(.PIX_AW(AW)) u_pix_engine (.*);

  always @(posedge clk) if (mem_en) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    else mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int first = -1;
    for (int i = 0; i < NPIX; i++) if (first < 0 && ram[i] !== ref_m[i]) first = i;
    total++;
    if (first >= 0) begin
      bad++;
      $display("FAIL %s pix %0d act=%0h exp=%0h", req, first, ram[first], ref_m[first]);
    end
  endtask

  // drive at negedge; returns after the accepting edge; reports stalled cycles
  task automatic bus_wr(input logic win, input logic [AW+2:0] a, input logic [31:0] d,
                        output int stalls);
    stalls = 0;
    bus_valid = 1; bus_we = 1; bus_win = win; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); stalls++; end
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic wait_idle();
    busy_cnt = 0;
    while (busy) begin busy_cnt++; @(negedge clk); end
  endtask

  task automatic set_col(input logic [31:0] c);
    int s;
    bus_wr(0, 13'h0, c, s);
    ref_col = c[7:0];
  endtask

  task automatic do_stip(input int d, input logic [31:0] m, input string req);
    int s;
    bus_wr(0, AW'(d) << 3 | 4, m, s);
    for (int i = 0; i < 32; i++)
      if (m[31-i]) ref_m[(d + i) % NPIX] = ref_col;
    wait_idle();
    chk({req, " R8 stipple busy"}, busy_cnt, 32);
    cmp_mem({req, " R3 stipple"});
  endtask

  task automatic do_fill(input int d, input int len, input string req);
    int s;
    bus_wr(1, AW'(d) << 3 | 4, {3'b0, 5'(len - 1), 24'hFFFFFF}, s);
    for (int i = 0; i < len; i++) ref_m[(d + i) % NPIX] = ref_col;
    wait_idle();
    chk({req, " R8 fill busy"}, busy_cnt, len);
    cmp_mem({req, " R5 fill"});
  endtask

  task automatic do_copy(input int d, input int sr, input int len, input string req);
    int s;
    bus_wr(1, AW'(d) << 3 | 4, {3'b0, 5'(len - 1), 24'(sr)}, s);
    for (int i = 0; i < len; i++) ref_m[(d + i) % NPIX] = ref_m[(sr + i) % NPIX];
    wait_idle();
    chk({req, " R8 copy busy"}, busy_cnt, 2 * len);
    cmp_mem({req, " R4 R6 copy"});
  endtask

  initial begin
    int s;
    logic [31:0] masks [6] = '{32'hFFFFFFFF, 32'h0, 32'h80000001, 32'hAAAA5555,
                               32'h0F0F00F0, 32'h00000001};
    for (int i = 0; i < NPIX; i++) begin ram[i] = 8'(i * 37 + 5); ref_m[i] = ram[i]; end
    ref_col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 ready", bus_ready, 1);
    chk("R11 mem_en", mem_en, 0);
    // R11 colour zero: fill with no colour written
    do_fill(40, 3, "R11");
    // R1 latch only
    set_col(32'h1234_56C3);
    #1 chk("R1 no busy", busy, 0);
    cmp_mem("R1 latch no mem");
    // R7 reads
    bus_valid = 1; bus_we = 0; bus_win = 1; bus_addr = 13'h1C; #1;
    chk("R7 rdata", bus_rdata, 0);
    chk("R7 ready", bus_ready, 1);
    @(posedge clk); @(negedge clk); bus_valid = 0;
    chk("R7 no start", busy, 0);
    cmp_mem("R7 no side effect");
    // R2 R3 stipple sweep, incl wrap R12
    foreach (masks[k]) begin
      set_col(32'h40 + k);
      do_stip(k * 100 + 3, masks[k], "R2");
    end
    set_col(32'h99);
    do_stip(NPIX - 5, 32'hFFFF0000, "R12");
    // fill all lengths
    for (int l = 1; l <= 32; l++) begin
      set_col(l * 7);
      do_fill((l * 29) % NPIX, l, "R4");
    end
    do_fill(NPIX - 3, 8, "R12");
    // copies: disjoint, forward overlap, backward overlap, wrap
    for (int l = 1; l <= 32; l++) begin
      int sr = (l * 31 + 200) % NPIX;
      int d = (l % 3 == 0) ? sr + 1 : (l % 3 == 1) ? sr - 2 : sr + 300;
      do_copy(d % NPIX, sr, l, "R6");
    end
    do_copy(NPIX - 4, NPIX - 10, 16, "R12");
    // R9 R10: latch while busy, trigger while busy
    set_col(32'h5A);
    bus_wr(1, 13'(500 << 3 | 4), {3'b0, 5'd31, 24'hFFFFFF}, s);
    for (int i = 0; i < 32; i++) ref_m[500 + i] = 8'h5A;
    chk("R10 busy during latch", busy, 1);
    set_col(32'hE7);
    bus_wr(1, 13'(600 << 3 | 4), {3'b0, 5'd1, 24'hFFFFFF}, s);
    chk("R9 stalled", s > 0, 1);
    ref_m[600] = 8'hE7; ref_m[601] = 8'hE7;
    wait_idle();
    cmp_mem("R10 R9 after stall");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 act=hung exp=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule